// File: doc/BRIEF.md
# Networked Interrupt Command Receiver

This block sits at one node of a ring network that carries memory writes and interrupt commands in the same stream. Each command names a destination node (or every node), one of three interrupt types, and the 8-bit ID of the node that sent it. When a command applies to this node, the block queues the sender's ID in a FIFO kept for that type. It raises that type's request line while the FIFO holds an entry and software has armed the type. The service routine reads the queued sender IDs back through a small register port. Each read pops one ID.

Commands stay in order with data. The block counts data transfers that have been received but not yet committed to memory. Each command waits in a short pending queue until every data transfer that arrived ahead of it has been committed. The block also holds the per-type level and vector settings as plain registers. A single host register write issues a new outgoing command that carries the node's own strapped ID as its origin.

Top module: `irq_cmd_rx`

## Requirements
- R1: After reset, irq_req and tx_valid are 0, the status register (address 2) reads 0, and the ID register (address 0) returns local_id in bits 7:0 with 0 above.
- R2: A command applies to this node when all three of these hold: its type is 0, 1 or 2; its origin differs from local_id; and either the broadcast flag is set or the target equals local_id. Its origin is then pushed into that type's FIFO. The effect is visible after the second rising edge following the receive cycle, provided no data is outstanding.
- R3: A command that does not apply leaves every FIFO untouched. This covers a command addressed to another node, a command of type 3, and a command whose origin is this node. The FIFO-non-empty bits (status bits 6:4, bit 4+t for type t) report this.
- R4: A command is acted on only after every data transfer received before it has been committed. Each mem_commit pulse retires the oldest outstanding data transfer. A pulse with nothing outstanding is ignored.
- R5: irq_req[t] is 1 exactly while type t is armed and its FIFO is non-empty. The arm register is at address 1, with bit t arming type t.
- R6: A read of address 4+t returns {7'b0, 1'b1, oldest ID} in bits 15:0 and removes that entry. On an empty FIFO it returns 0 and nothing changes.
- R7: A command that applies to a full FIFO drops its ID and sets sticky status bit t. The request stays asserted. Writing 1 to a status bit clears it.
- R8: A command arriving while the pending queue is full is discarded and sets sticky status bit 3, which is cleared by writing 1.
- R9: A write to address 3 carries the target in wdata[7:0], the broadcast flag in wdata[8] and the type in wdata[10:9]. It drives tx_valid high for exactly the next cycle, with those fields and tx_origin equal to local_id.
- R10: Address 8+t is a read/write register holding the vector in bits 7:0 and the level in bits 10:8 for type t. These appear on irq_vector[8t+7:8t] and irq_level[3t+2:3t].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| local_id | input | 8 | Strapped ID of this node |
| rx_valid | input | 1 | A transfer arrives from the ring this cycle |
| rx_is_cmd | input | 1 | 1: interrupt command, 0: data transfer |
| rx_target | input | 8 | Destination node of the command |
| rx_bcast | input | 1 | Command targets every node |
| rx_type | input | 2 | Interrupt type of the command |
| rx_origin | input | 8 | Node that issued the command |
| mem_commit | input | 1 | The oldest outstanding data transfer has been written to memory |
| host_addr | input | 4 | Register address |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe (pops on FIFO addresses) |
| host_wdata | input | 16 | Register write data |
| host_rdata | output | 16 | Register read data for host_addr |
| irq_req | output | 3 | Per-type interrupt request |
| irq_level | output | 9 | Per-type level, 3 bits each |
| irq_vector | output | 24 | Per-type vector, 8 bits each |
| tx_valid | output | 1 | Outgoing command valid for one cycle |
| tx_target | output | 8 | Outgoing command target |
| tx_bcast | output | 1 | Outgoing command broadcast flag |
| tx_type | output | 2 | Outgoing command type |
| tx_origin | output | 8 | Outgoing command origin |

## Verification
The bench builds the block with a 4-entry ID FIFO per type and a 4-entry pending queue. This lets five commands fill and overflow a FIFO, or fill and overflow the pending queue, within a few cycles. With only three outstanding data transfers, the bench can hold a command back and then release it one commit at a time. Random traffic mixes matching, foreign, broadcast, self-originated and type-3 commands with pops, all against a per-type queue model that saturates at the same depth.

// File: rtl/irq_rx_pkg.sv
package irq_rx_pkg;
  localparam int NTYPES = 3;

  typedef logic [7:0] node_id_t;

  typedef struct packed {
    node_id_t   target;
    logic       bcast;
    logic [1:0] kind;
    node_id_t   origin;
  } irq_cmd_t;

  localparam logic [3:0] A_ID     = 4'd0;
  localparam logic [3:0] A_ARM    = 4'd1;
  localparam logic [3:0] A_STATUS = 4'd2;
  localparam logic [3:0] A_GEN    = 4'd3;
  localparam logic [3:0] A_POP0   = 4'd4;
  localparam logic [3:0] A_CFG0   = 4'd8;

  function automatic logic cmd_applies(irq_cmd_t c, node_id_t me);
    return (c.kind != 2'd3) && (c.origin != me) && (c.bcast || (c.target == me));
  endfunction

  function automatic irq_cmd_t gen_decode(logic [15:0] w, node_id_t me);
    irq_cmd_t c;
    c.target = w[7:0];
    c.bcast  = w[8];
    c.kind   = w[10:9];
    c.origin = me;
    return c;
  endfunction
endpackage

// File: rtl/irq_id_fifo.sv
module irq_id_fifo #(
  parameter int DEPTH = 512,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] ptr_next(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (cnt == CW'(DEPTH));
  assign empty   = (cnt == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= ptr_next(wp);
      if (do_pop)  rp <= ptr_next(rp);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/irq_order_q.sv
module irq_order_q
  import irq_rx_pkg::*;
#(
  parameter int PEND = 4,
  parameter int CW   = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          data_in,
  input  logic          cmd_in,
  input  irq_cmd_t      cmd_d,
  input  logic          commit,
  output logic          exec,
  output irq_cmd_t      head,
  output logic          drop,
  output logic [CW-1:0] out_cnt
);
  localparam int QW = $clog2(PEND + 1);

  irq_cmd_t      ent_q [PEND];
  irq_cmd_t      ent_d [PEND];
  logic [CW-1:0] wt_q  [PEND];
  logic [CW-1:0] wt_d  [PEND];
  logic [QW-1:0] n_q, n_d, ins;
  logic          commit_eff, accept;

  function automatic logic [CW-1:0] retire(logic [CW-1:0] w, logic c);
    return (c && (w != '0)) ? w - 1'b1 : w;
  endfunction

  assign commit_eff = commit && (out_cnt != '0);
  assign exec       = (n_q != '0) && (wt_q[0] == '0);
  assign accept     = cmd_in && (n_q != QW'(PEND));
  assign drop       = cmd_in && !accept;
  assign head       = ent_q[0];
  assign ins        = n_q - QW'(exec);

  always_comb begin
    n_d = ins + QW'(accept);
    for (int i = 0; i < PEND; i++) begin
      if (exec && (i < PEND - 1)) begin
        ent_d[i] = ent_q[i + 1];
        wt_d[i]  = retire(wt_q[i + 1], commit_eff);
      end else begin
        ent_d[i] = ent_q[i];
        wt_d[i]  = retire(wt_q[i], commit_eff);
      end
    end
    if (accept) begin
      ent_d[ins] = cmd_d;
      wt_d[ins]  = out_cnt - CW'(commit_eff);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_q     <= '0;
      out_cnt <= '0;
      for (int i = 0; i < PEND; i++) begin
        ent_q[i] <= '0;
        wt_q[i]  <= '0;
      end
    end else begin
      n_q     <= n_d;
      out_cnt <= out_cnt + CW'(data_in) - CW'(commit_eff);
      for (int i = 0; i < PEND; i++) begin
        ent_q[i] <= ent_d[i];
        wt_q[i]  <= wt_d[i];
      end
    end
  end
endmodule

// File: rtl/irq_cmd_rx.sv
module irq_cmd_rx
  import irq_rx_pkg::*;
#(
  parameter int FIFO_DEPTH = 512,
  parameter int PEND_DEPTH = 4,
  parameter int CNT_W      = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  local_id,
  input  logic        rx_valid,
  input  logic        rx_is_cmd,
  input  logic [7:0]  rx_target,
  input  logic        rx_bcast,
  input  logic [1:0]  rx_type,
  input  logic [7:0]  rx_origin,
  input  logic        mem_commit,
  input  logic [3:0]  host_addr,
  input  logic        host_wr,
  input  logic        host_rd,
  input  logic [15:0] host_wdata,
  output logic [15:0] host_rdata,
  output logic [2:0]  irq_req,
  output logic [8:0]  irq_level,
  output logic [23:0] irq_vector,
  output logic        tx_valid,
  output logic [7:0]  tx_target,
  output logic        tx_bcast,
  output logic [1:0]  tx_type,
  output logic [7:0]  tx_origin
);
  irq_cmd_t             rx_cmd, head, gen_cmd;
  logic                 exec_fire, exec_hit, drop_ev, gen_wr, stat_wr;
  logic [CNT_W-1:0]     out_cnt;
  logic [NTYPES-1:0]    push_t, pop_t, full_t, empty_t, arm_q, ovf_q;
  logic                 drop_q;
  logic [7:0]           head_id [NTYPES];
  logic [7:0]           vec_q   [NTYPES];
  logic [2:0]           lvl_q   [NTYPES];

  assign rx_cmd  = '{target: rx_target, bcast: rx_bcast, kind: rx_type, origin: rx_origin};
  assign gen_wr  = host_wr && (host_addr == A_GEN);
  assign stat_wr = host_wr && (host_addr == A_STATUS);
  assign gen_cmd = gen_decode(host_wdata, local_id);

  irq_order_q #(.PEND(PEND_DEPTH), .CW(CNT_W)) u_order (
    .clk     (clk),
    .rst_n   (rst_n),
    .data_in (rx_valid && !rx_is_cmd),
    .cmd_in  (rx_valid && rx_is_cmd),
    .cmd_d   (rx_cmd),
    .commit  (mem_commit),
    .exec    (exec_fire),
    .head    (head),
    .drop    (drop_ev),
    .out_cnt (out_cnt)
  );

  assign exec_hit = exec_fire && cmd_applies(head, local_id);

  for (genvar t = 0; t < NTYPES; t++) begin : g_type
    assign push_t[t] = exec_hit && (head.kind == 2'(t));
    assign pop_t[t]  = host_rd && (host_addr == 4'(A_POP0 + t));

    irq_id_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (push_t[t]),
      .din   (head.origin),
      .pop   (pop_t[t]),
      .dout  (head_id[t]),
      .empty (empty_t[t]),
      .full  (full_t[t])
    );

    assign irq_vector[8*t +: 8] = vec_q[t];
    assign irq_level[3*t +: 3]  = lvl_q[t];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vec_q[t] <= '0;
        lvl_q[t] <= '0;
      end else if (host_wr && (host_addr == 4'(A_CFG0 + t))) begin
        vec_q[t] <= host_wdata[7:0];
        lvl_q[t] <= host_wdata[10:8];
      end
    end
  end

  assign irq_req = arm_q & ~empty_t;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_q     <= '0;
      ovf_q     <= '0;
      drop_q    <= 1'b0;
      tx_valid  <= 1'b0;
      tx_target <= '0;
      tx_bcast  <= 1'b0;
      tx_type   <= '0;
      tx_origin <= '0;
    end else begin
      if (host_wr && (host_addr == A_ARM)) arm_q <= host_wdata[2:0];
      ovf_q  <= (ovf_q & ~(stat_wr ? host_wdata[2:0] : 3'b000)) | (push_t & full_t);
      drop_q <= (drop_q && !(stat_wr && host_wdata[3])) || drop_ev;
      tx_valid <= gen_wr;
      if (gen_wr) begin
        tx_target <= gen_cmd.target;
        tx_bcast  <= gen_cmd.bcast;
        tx_type   <= gen_cmd.kind;
        tx_origin <= gen_cmd.origin;
      end
    end
  end

  always_comb begin
    host_rdata = '0;
    case (host_addr)
      A_ID:     host_rdata = {8'h00, local_id};
      A_ARM:    host_rdata = {13'h0, arm_q};
      A_STATUS: host_rdata = {9'h0, ~empty_t, drop_q, ovf_q};
      4'd4, 4'd5, 4'd6: begin
        if (!empty_t[host_addr - A_POP0])
          host_rdata = {7'h0, 1'b1, head_id[host_addr - A_POP0]};
      end
      4'd8, 4'd9, 4'd10:
        host_rdata = {5'h0, lvl_q[host_addr - A_CFG0], vec_q[host_addr - A_CFG0]};
      default:  host_rdata = '0;
    endcase
  end
endmodule

// File: rtl/irq_cmd_rx_chk.sv
module irq_cmd_rx_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [7:0]       local_id,
  input logic             rx_valid,
  input logic             rx_is_cmd,
  input logic             mem_commit,
  input logic [3:0]       host_addr,
  input logic             host_wr,
  input logic [2:0]       irq_req,
  input logic             tx_valid,
  input logic [7:0]       tx_origin,
  input logic             exec_fire,
  input logic [2:0]       push_t,
  input logic [2:0]       full_t,
  input logic [2:0]       ovf_q,
  input logic [CNT_W-1:0] out_cnt
);
  // R4
  commit_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_commit && (out_cnt == '0) && !(rx_valid && !rx_is_cmd)) |=> (out_cnt == '0));

  // R4
  data_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_is_cmd && !mem_commit) |=> (out_cnt == $past(out_cnt) + 1'b1));

  // R9
  gen_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && (host_addr == 4'd3)) |=> (tx_valid && (tx_origin == $past(local_id))));

  for (genvar t = 0; t < 3; t++) begin : g_chk
    // R7
    overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push_t[t] && full_t[t]) |=> ovf_q[t]);

    // R2
    push_from_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      push_t[t] |-> exec_fire);

    // R5
    req_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_req[t]) |-> $past(push_t[t] || (host_wr && (host_addr == 4'd1))));
  end
endmodule

bind irq_cmd_rx irq_cmd_rx_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .local_id   (local_id),
  .rx_valid   (rx_valid),
  .rx_is_cmd  (rx_is_cmd),
  .mem_commit (mem_commit),
  .host_addr  (host_addr),
  .host_wr    (host_wr),
  .irq_req    (irq_req),
  .tx_valid   (tx_valid),
  .tx_origin  (tx_origin),
  .exec_fire  (exec_fire),
  .push_t     (push_t),
  .full_t     (full_t),
  .ovf_q      (ovf_q),
  .out_cnt    (out_cnt)
);

// File: tb/irq_cmd_rx_tb.sv
module irq_cmd_rx_tb;
  localparam int DEPTH = 4;
  localparam logic [7:0] ME    = 8'h2A;
  localparam logic [7:0] OTHER = 8'h2B;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_valid = 0, rx_is_cmd = 0, rx_bcast = 0, mem_commit = 0;
  logic [7:0]  rx_target = 0, rx_origin = 0;
  logic [1:0]  rx_type = 0;
  logic [3:0]  host_addr = 0;
  logic        host_wr = 0, host_rd = 0;
  logic [15:0] host_wdata = 0, host_rdata;
  logic [2:0]  irq_req;
  logic [8:0]  irq_level;
  logic [23:0] irq_vector;
  logic        tx_valid, tx_bcast;
  logic [7:0]  tx_target, tx_origin;
  logic [1:0]  tx_type;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] mq0[$], mq1[$], mq2[$];

  always #2 clk = ~clk;

  irq_cmd_rx #(.FIFO_DEPTH(DEPTH), .PEND_DEPTH(4), .CNT_W(16)) u_dut (
    .clk(clk), .rst_n(rst_n), .local_id(ME),
    .rx_valid(rx_valid), .rx_is_cmd(rx_is_cmd), .rx_target(rx_target),
    .rx_bcast(rx_bcast), .rx_type(rx_type), .rx_origin(rx_origin),
    .mem_commit(mem_commit), .host_addr(host_addr), .host_wr(host_wr),
    .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .irq_req(irq_req), .irq_level(irq_level), .irq_vector(irq_vector),
    .tx_valid(tx_valid), .tx_target(tx_target), .tx_bcast(tx_bcast),
    .tx_type(tx_type), .tx_origin(tx_origin)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit applies(logic [7:0] tgt, logic bc, logic [1:0] ty, logic [7:0] org);
    if (ty == 2'd3) return 0;
    if (org == ME) return 0;
    return bc || (tgt == ME);
  endfunction

  task automatic hwrite(logic [3:0] a, logic [15:0] d);
    host_addr = a; host_wdata = d; host_wr = 1;
    @(negedge clk);
    host_wr = 0;
  endtask

  task automatic hread(logic [3:0] a, output logic [15:0] d);
    host_addr = a; host_rd = 1;
    #1 d = host_rdata;
    @(negedge clk);
    host_rd = 0;
  endtask

  task automatic peek(logic [3:0] a, output logic [15:0] d);
    host_addr = a;
    #1 d = host_rdata;
  endtask

  task automatic send_cmd(logic [7:0] tgt, logic bc, logic [1:0] ty, logic [7:0] org);
    rx_valid = 1; rx_is_cmd = 1; rx_target = tgt; rx_bcast = bc; rx_type = ty; rx_origin = org;
    @(negedge clk);
    rx_valid = 0; rx_is_cmd = 0;
    @(negedge clk);
  endtask

  task automatic send_data();
    rx_valid = 1; rx_is_cmd = 0;
    @(negedge clk);
    rx_valid = 0;
  endtask

  task automatic commit1();
    mem_commit = 1;
    @(negedge clk);
    mem_commit = 0;
  endtask

  task automatic model_push(logic [1:0] ty, logic [7:0] org);
    case (ty)
      2'd0: if (mq0.size() < DEPTH) mq0.push_back(org);
      2'd1: if (mq1.size() < DEPTH) mq1.push_back(org);
      2'd2: if (mq2.size() < DEPTH) mq2.push_back(org);
      default: ;
    endcase
  endtask

  task automatic model_pop_check(int t);
    logic [15:0] d, e;
    e = 16'h0;
    case (t)
      0: if (mq0.size() > 0) e = {8'h01, mq0.pop_front()};
      1: if (mq1.size() > 0) e = {8'h01, mq1.pop_front()};
      default: if (mq2.size() > 0) e = {8'h01, mq2.pop_front()};
    endcase
    hread(4'(4 + t), d);
    check("R6 random pop", {16'h0, d}, {16'h0, e});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    check("R1 irq_req", {29'h0, irq_req}, 0);
    check("R1 tx_valid", {31'h0, tx_valid}, 0);
    peek(4'd0, d); check("R1 id reg", {16'h0, d}, {24'h0, ME});
    peek(4'd2, d); check("R1 status", {16'h0, d}, 0);

    // R5 unarmed: queued, no request; arming raises it
    send_cmd(ME, 0, 2'd0, 8'h05);
    peek(4'd2, d); check("R2 nonempty after accept", {16'h0, d}, 32'h10);
    check("R5 unarmed no request", {29'h0, irq_req}, 0);
    hwrite(4'd1, 16'h0007);
    check("R5 armed request", {29'h0, irq_req}, 32'h1);
    hread(4'd4, d); check("R6 pop origin", {16'h0, d}, 32'h0105);
    check("R5 request drops when empty", {29'h0, irq_req}, 0);
    hread(4'd4, d); check("R6 empty pop", {16'h0, d}, 0);

    // R3 ignored commands
    send_cmd(OTHER, 0, 2'd1, 8'h05);
    send_cmd(ME, 0, 2'd3, 8'h05);
    send_cmd(8'h00, 1, 2'd2, ME);
    peek(4'd2, d); check("R3 nothing queued", {16'h0, d}, 0);
    check("R3 no request", {29'h0, irq_req}, 0);

    // R2 broadcast
    send_cmd(8'h99, 1, 2'd1, 8'h11);
    check("R2 broadcast request", {29'h0, irq_req}, 32'h2);
    hread(4'd5, d); check("R2 broadcast origin", {16'h0, d}, 32'h0111);

    // R4 ordering behind data
    send_data(); send_data(); send_data();
    send_cmd(ME, 0, 2'd0, 8'h33);
    check("R4 held behind 3 data", {29'h0, irq_req}, 0);
    commit1(); commit1();
    @(negedge clk);
    check("R4 held behind 1 data", {29'h0, irq_req}, 0);
    commit1();
    @(negedge clk);
    check("R4 released after commits", {29'h0, irq_req}, 32'h1);
    hread(4'd4, d); check("R4 origin", {16'h0, d}, 32'h0133);
    commit1();
    send_cmd(ME, 0, 2'd0, 8'h34);
    check("R4 extra commit ignored", {29'h0, irq_req}, 32'h1);
    hread(4'd4, d);

    // R7 FIFO overflow
    for (int i = 0; i < 5; i++) send_cmd(ME, 0, 2'd2, 8'(8'h40 + i));
    peek(4'd2, d); check("R7 overflow sticky", {16'h0, d}, 32'h44);
    check("R7 request held", {29'h0, irq_req}, 32'h4);
    for (int i = 0; i < 4; i++) begin
      hread(4'd6, d); check("R7 order kept", {16'h0, d}, 32'(16'h0140 + i));
    end
    hread(4'd6, d); check("R7 newest dropped", {16'h0, d}, 0);
    hwrite(4'd2, 16'h0004);
    peek(4'd2, d); check("R7 w1c", {16'h0, d}, 0);

    // R8 pending queue overflow
    send_data();
    for (int i = 0; i < 5; i++) begin
      rx_valid = 1; rx_is_cmd = 1; rx_target = ME; rx_bcast = 0; rx_type = 2'd1;
      rx_origin = 8'(8'h50 + i);
      @(negedge clk);
    end
    rx_valid = 0; rx_is_cmd = 0;
    peek(4'd2, d); check("R8 drop sticky", {16'h0, d}, 32'h08);
    commit1();
    repeat (5) @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      hread(4'd5, d); check("R8 kept commands", {16'h0, d}, 32'(16'h0150 + i));
    end
    hwrite(4'd2, 16'h0008);
    peek(4'd2, d); check("R8 w1c", {16'h0, d}, 0);

    // R9 outgoing command
    hwrite(4'd3, {5'h0, 2'd2, 1'b1, 8'h77});
    check("R9 tx_valid", {31'h0, tx_valid}, 1);
    check("R9 tx fields", {13'h0, tx_bcast, tx_type, tx_target, tx_origin}, {13'h0, 1'b1, 2'd2, 8'h77, ME});
    @(negedge clk);
    check("R9 single cycle", {31'h0, tx_valid}, 0);

    // R10 config registers
    hwrite(4'd9, 16'h05A7);
    peek(4'd9, d); check("R10 readback", {16'h0, d}, 32'h05A7);
    check("R10 level out", {29'h0, irq_level[5:3]}, 5);
    check("R10 vector out", {24'h0, irq_vector[15:8]}, 32'hA7);

    // Random mix against model
    for (int it = 0; it < 300; it++) begin
      int op;
      op = $urandom % 3;
      if (op < 2) begin
        logic [7:0] tgt, org;
        logic bc;
        logic [1:0] ty;
        tgt = ($urandom % 3 == 0) ? OTHER : ME;
        bc  = ($urandom % 4 == 0);
        ty  = 2'($urandom % 4);
        org = ($urandom % 8 == 0) ? ME : 8'($urandom);
        send_cmd(tgt, bc, ty, org);
        if (applies(tgt, bc, ty, org)) model_push(ty, org);
        check("R2 R3 random request", {29'h0, irq_req},
              {29'h0, mq2.size() > 0, mq1.size() > 0, mq0.size() > 0});
      end else begin
        model_pop_check(int'($urandom % 3));
      end
    end
    for (int t = 0; t < 3; t++)
      for (int k = 0; k <= DEPTH; k++) model_pop_check(t);
    check("R5 all drained", {29'h0, irq_req}, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule